// File: doc/BRIEF.md
# Memory-Bus to Register Bridge

This block is a slave on a host's synchronous external memory bus. The bus has a rising-edge bus clock, an active-low select, an active-low address strobe, active-low write and read enables, a 22-bit address and a shared 32-bit data bus. The slave answers with an active-low ready line. Each host access becomes exactly one single-cycle write or read strobe on an internal register bus. That register bus runs from its own, slower clock.

An access opens on the bus clock edge where select and address strobe are both low. On that edge the bridge captures the address and the direction, and it pulls the ready line low. A write waits a fixed number of bus clocks and then captures the write data. A read sends its request at once. Requests and acknowledges cross between the two clock domains as toggle events through two-flop synchronisers. The address, data and direction are held steady while a request is in flight. The ready line rises only after the register-bus side has finished. For a read, the returned word must also be registered on the bus side and the bridge must already be driving it. The host completes the data phase on the first rising bus clock at which it saw ready high.

Top module: `membus_bridge`

## Requirements
- R1: An access starts only on a rising bus clock where `bus_cs_n` and `bus_adv_n` are both 0, and `bus_addr` is captured on that edge. Select low with the address strobe high, or the address strobe low with select high, starts nothing: no register strobe is issued and `bus_wait_n` stays 1.
- R2: `bus_wait_n` is 1 during and after reset and while idle. It is 0 from the rising edge that starts an access.
- R3: For a write (`bus_we_n` = 0 at the start edge), the data bus is sampled on the rising edge that comes DATA_LAT+1 edges after the start edge. Exactly one `sys_wr` pulse follows, with `sys_addr` equal to the captured address and `sys_wdata` equal to the sampled word.
- R4: For a read (`bus_we_n` = 1 at the start edge), exactly one `sys_rd` pulse is issued, with `sys_addr` equal to the captured address. `sys_rdata` is sampled on the register-clock edge that ends the cycle after the `sys_rd` cycle.
- R5: During a read, the host holds `bus_oe_n` at 0. On the first rising edge at which `bus_wait_n` was 1, the data bus carries the word returned by R4.
- R6: The bridge drives the data bus only when select and read-enable were both 0 at the previous rising bus clock. It never drives the bus while a write is selected.
- R7: `sys_wr` and `sys_rd` are each high for exactly one register-clock cycle per access, and they are never high together.
- R8: `bus_wait_n` returns to 1 only after the register-side transfer has been acknowledged. For a read, the bridge must also already be driving the bus. Accesses issued back to back, each one starting as soon as ready is high, all complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Host memory-bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| bus_cs_n | input | 1 | Active-low select |
| bus_adv_n | input | 1 | Active-low address strobe, one bus clock long |
| bus_we_n | input | 1 | Active-low write enable, held for a whole write |
| bus_oe_n | input | 1 | Active-low read output enable |
| bus_addr | input | ADDR_W (22) | Access address |
| bus_data | inout | DATA_W (32) | Shared data bus |
| bus_wait_n | output | 1 | Active-low ready; host must hold while 0 |
| sys_clk | input | 1 | Register-bus clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, register domain |
| sys_addr | output | ADDR_W (22) | Register address |
| sys_wr | output | 1 | One-cycle write strobe |
| sys_wdata | output | DATA_W (32) | Write data, valid with `sys_wr` |
| sys_rd | output | 1 | One-cycle read strobe |
| sys_rdata | input | DATA_W (32) | Read data, valid the cycle after `sys_rd` |

## Verification
The bench builds the bridge with ADDR_W = 6, DATA_W = 16 and DATA_LAT = 2. The whole 64-entry address space can then be swept. It writes every address and reads every address back in reverse order. It then runs one more interleaved write/read pass with a second arithmetic data pattern. With these widths, an aliased address bit, a write-data sample taken one edge early, and a stale read word all show up as miscompares. The bus clock and the register clock are not related by any integer ratio, so the crossing is exercised at many different phase offsets.

// File: rtl/membus_pkg.sv
`timescale 1ns/1ps
// membus_pkg
// Shared state encodings for the memory-bus bridge.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package membus_pkg;

    // Bus-domain access sequencer states
    typedef enum logic [2:0] {
        B_IDLE,   // waiting for select + address strobe
        B_WLAT,   // counting write-data latency
        B_BUSY,   // request in flight, waiting for acknowledge
        B_FIN,    // acknowledge seen, release ready when safe
        B_DONE    // ready high, waiting for host to deselect
    } bus_st_t;

    // Register-domain strobe generator states
    typedef enum logic [1:0] {
        S_IDLE,   // waiting for a request toggle
        S_STROBE, // strobe cycle on the register bus
        S_RDCAP   // capture read data and acknowledge
    } sys_st_t;

endpackage

// File: rtl/membus_tog_sync.sv
`timescale 1ns/1ps
// membus_tog_sync
// Multi-flop synchroniser for a single toggle signal entering clk's domain.
// Assumes: d changes at most once per several destination clocks (toggle protocol).
module membus_tog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_q;

    // Shift the asynchronous toggle through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/membus_bus_side.sv
`timescale 1ns/1ps
// membus_bus_side
// Bus-clock sequencer: decodes access starts, times the write-data phase,
// raises request toggles, waits for acknowledges and controls ready and
// the data-bus driver.
// Assumes: host obeys ready, holds select until ready was seen high, and
// keeps addr/wdata request fields untouched only through this module.
module membus_bus_side
    import membus_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 32,
    parameter int DATA_LAT    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wait_n,
    output logic              drv,
    output logic [DATA_W-1:0] dout,
    output logic              req_tgl,
    output logic              req_wr,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              ack_tgl,
    input  logic [DATA_W-1:0] ack_rdata
);

    localparam int CNT_W = $clog2(DATA_LAT + 1);

    bus_st_t           st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ack_s;
    logic              ack_seen_q;

    // Bring the acknowledge toggle into the bus domain
    membus_tog_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    // Access sequencer, ready line and registered driver enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= B_IDLE;
            cnt_q      <= '0;
            wait_n     <= 1'b1;
            drv        <= 1'b0;
            req_tgl    <= 1'b0;
            req_wr     <= 1'b0;
            req_addr   <= '0;
            req_wdata  <= '0;
            ack_seen_q <= 1'b0;
            dout       <= '0;
        end else begin
            drv <= !cs_n && !oe_n;
            case (st_q)
                B_IDLE: begin
                    if (!cs_n && !adv_n) begin
                        req_addr <= addr;
                        req_wr   <= !we_n;
                        wait_n   <= 1'b0;
                        cnt_q    <= '0;
                        if (!we_n) begin
                            st_q <= B_WLAT;
                        end else begin
                            req_tgl <= !req_tgl;
                            st_q    <= B_BUSY;
                        end
                    end
                end
                B_WLAT: begin
                    if (cnt_q == CNT_W'(DATA_LAT)) begin
                        req_wdata <= din;
                        req_tgl   <= !req_tgl;
                        st_q      <= B_BUSY;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                B_BUSY: begin
                    if (ack_s != ack_seen_q) begin
                        ack_seen_q <= ack_s;
                        dout       <= ack_rdata;
                        st_q       <= B_FIN;
                    end
                end
                B_FIN: begin
                    if (req_wr || drv) begin
                        wait_n <= 1'b1;
                        st_q   <= B_DONE;
                    end
                end
                B_DONE: begin
                    if (cs_n) st_q <= B_IDLE;
                end
                default: st_q <= B_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/membus_sys_side.sv
`timescale 1ns/1ps
// membus_sys_side
// Register-clock side: turns each request toggle into one write or read
// strobe, captures read data, and answers with an acknowledge toggle.
// Assumes: req_wr/req_addr/req_wdata are stable from the toggle until the
// acknowledge; sys_rdata is valid in the cycle after the read strobe.
module membus_sys_side
    import membus_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] ack_rdata,
    output logic [ADDR_W-1:0] sys_addr,
    output logic              sys_wr,
    output logic [DATA_W-1:0] sys_wdata,
    output logic              sys_rd,
    input  logic [DATA_W-1:0] sys_rdata
);

    sys_st_t st_q;
    logic    req_s;
    logic    req_seen_q;

    // Bring the request toggle into the register domain
    membus_tog_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    // Strobe generator, read capture and acknowledge toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= S_IDLE;
            req_seen_q <= 1'b0;
            ack_tgl    <= 1'b0;
            ack_rdata  <= '0;
            sys_addr   <= '0;
            sys_wr     <= 1'b0;
            sys_wdata  <= '0;
            sys_rd     <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (req_s != req_seen_q) begin
                        req_seen_q <= req_s;
                        sys_addr   <= req_addr;
                        if (req_wr) begin
                            sys_wr    <= 1'b1;
                            sys_wdata <= req_wdata;
                        end else begin
                            sys_rd <= 1'b1;
                        end
                        st_q <= S_STROBE;
                    end
                end
                S_STROBE: begin
                    sys_wr <= 1'b0;
                    sys_rd <= 1'b0;
                    if (sys_wr) begin
                        ack_tgl <= !ack_tgl;
                        st_q    <= S_IDLE;
                    end else begin
                        st_q <= S_RDCAP;
                    end
                end
                S_RDCAP: begin
                    ack_rdata <= sys_rdata;
                    ack_tgl   <= !ack_tgl;
                    st_q      <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/membus_bridge.sv
`timescale 1ns/1ps
// membus_bridge
// Top level: synchronous memory-bus slave bridged into a register bus on
// an independent clock. Holds the data-bus tristate.
// Assumes: both resets are held low for several clocks of their domain.
module membus_bridge #(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 32,
    parameter int DATA_LAT    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_adv_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic              bus_wait_n,
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    output logic [ADDR_W-1:0] sys_addr,
    output logic              sys_wr,
    output logic [DATA_W-1:0] sys_wdata,
    output logic              sys_rd,
    input  logic [DATA_W-1:0] sys_rdata
);

    logic              bus_drv;
    logic [DATA_W-1:0] bus_dout;
    logic              req_tgl;
    logic              req_wr;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              ack_tgl;
    logic [DATA_W-1:0] ack_rdata;

    // Tristate: drive only on the registered read enable
    assign bus_data = bus_drv ? bus_dout : 'z;

    membus_bus_side #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .DATA_LAT    (DATA_LAT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_bus (
        .clk       (bus_clk),
        .rst_n     (bus_rst_n),
        .cs_n      (bus_cs_n),
        .adv_n     (bus_adv_n),
        .we_n      (bus_we_n),
        .oe_n      (bus_oe_n),
        .addr      (bus_addr),
        .din       (bus_data),
        .wait_n    (bus_wait_n),
        .drv       (bus_drv),
        .dout      (bus_dout),
        .req_tgl   (req_tgl),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ack_tgl   (ack_tgl),
        .ack_rdata (ack_rdata)
    );

    membus_sys_side #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sys (
        .clk       (sys_clk),
        .rst_n     (sys_rst_n),
        .req_tgl   (req_tgl),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ack_tgl   (ack_tgl),
        .ack_rdata (ack_rdata),
        .sys_addr  (sys_addr),
        .sys_wr    (sys_wr),
        .sys_wdata (sys_wdata),
        .sys_rd    (sys_rd),
        .sys_rdata (sys_rdata)
    );

endmodule

// File: rtl/membus_bridge_chk.sv
`timescale 1ns/1ps
// membus_bridge_chk
// Protocol checker for membus_bridge, attached with bind below.
// Assumes: the host obeys the ready line.
module membus_bridge_chk (
    input logic bus_clk,
    input logic bus_rst_n,
    input logic bus_cs_n,
    input logic bus_adv_n,
    input logic bus_we_n,
    input logic bus_wait_n,
    input logic drv,
    input logic sys_clk,
    input logic sys_rst_n,
    input logic sys_wr,
    input logic sys_rd
);

    AST_START_DROPS_READY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!bus_cs_n && !bus_adv_n && bus_wait_n) |=> !bus_wait_n) else $error("ready not dropped"); // R2

    AST_DESELECT_NO_START: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_cs_n && bus_wait_n) |=> bus_wait_n) else $error("start while deselected"); // R1

    AST_NO_DRIVE_IN_WRITE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!bus_cs_n && !bus_we_n) |-> !drv) else $error("driving during write"); // R6

    AST_READ_READY_DRIVEN: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        ($rose(bus_wait_n) && bus_we_n) |-> drv) else $error("ready before driver"); // R8

    AST_WR_ONE_CYCLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        sys_wr |=> !sys_wr) else $error("long write strobe"); // R7

    AST_RD_ONE_CYCLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        sys_rd |=> !sys_rd) else $error("long read strobe"); // R7

    AST_STROBES_EXCL: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !(sys_wr && sys_rd)) else $error("both strobes"); // R7

endmodule

bind membus_bridge membus_bridge_chk u_chk (
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .bus_cs_n   (bus_cs_n),
    .bus_adv_n  (bus_adv_n),
    .bus_we_n   (bus_we_n),
    .bus_wait_n (bus_wait_n),
    .drv        (bus_drv),
    .sys_clk    (sys_clk),
    .sys_rst_n  (sys_rst_n),
    .sys_wr     (sys_wr),
    .sys_rd     (sys_rd)
);

// File: tb/membus_bridge_tb.sv
`timescale 1ns/1ps
module membus_bridge_tb;

    localparam int AW  = 6;
    localparam int DW  = 16;
    localparam int LAT = 2;
    localparam int NA  = 1 << AW;

    logic bus_clk = 1'b0;
    logic sys_clk = 1'b0;
    logic rst_n   = 1'b0;
    always #2.5 bus_clk = ~bus_clk;
    always #6   sys_clk = ~sys_clk;

    logic          cs_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          host_drv = 1'b0;
    logic [DW-1:0] host_val = '0;
    wire  [DW-1:0] bus_data;
    logic          wait_n;
    logic [AW-1:0] sys_addr;
    logic          sys_wr, sys_rd;
    logic [DW-1:0] sys_wdata;
    logic [DW-1:0] sys_rdata = '0;

    assign bus_data = host_drv ? host_val : 'z;

    membus_bridge #(.ADDR_W(AW), .DATA_W(DW), .DATA_LAT(LAT), .SYNC_STAGES(2)) u_dut (
        .bus_clk(bus_clk), .bus_rst_n(rst_n), .bus_cs_n(cs_n), .bus_adv_n(adv_n),
        .bus_we_n(we_n), .bus_oe_n(oe_n), .bus_addr(addr), .bus_data(bus_data),
        .bus_wait_n(wait_n), .sys_clk(sys_clk), .sys_rst_n(rst_n), .sys_addr(sys_addr),
        .sys_wr(sys_wr), .sys_wdata(sys_wdata), .sys_rd(sys_rd), .sys_rdata(sys_rdata)
    );

    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, rd_cnt = 0, dbl = 0;
    logic [AW-1:0] last_waddr = '0, last_raddr = '0;
    logic [DW-1:0] last_wdata = '0;
    logic prev_wr = 1'b0, prev_rd = 1'b0;
    logic [DW-1:0] mem [0:NA-1];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'(a * 977 + 4661);
    endfunction

    function automatic logic [DW-1:0] pat2(input int a);
        return DW'((a * 40503) ^ 50085);
    endfunction

    // register-bus model and strobe monitor, away from the design's edge
    always @(negedge sys_clk) begin
        if (sys_wr === 1'b1) begin
            mem[sys_addr] = sys_wdata;
            wr_cnt++;
            last_waddr = sys_addr;
            last_wdata = sys_wdata;
        end
        if (sys_rd === 1'b1) begin
            sys_rdata <= mem[sys_addr];
            rd_cnt++;
            last_raddr = sys_addr;
        end
        if ((sys_wr && prev_wr) || (sys_rd && prev_rd) || (sys_wr && sys_rd)) dbl++;
        prev_wr = sys_wr;
        prev_rd = sys_rd;
    end

    task automatic wait_ready();
        int  n;
        logic w;
        n = 0;
        do begin
            w = wait_n;
            @(negedge bus_clk);
            n++;
        end while (!w && n < 400);
        check(n < 400, "R8", n, 0);
    endtask

    task automatic host_write(input int a, input logic [DW-1:0] d);
        int c0;
        c0 = wr_cnt;
        @(negedge bus_clk);
        cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; addr = AW'(a);
        @(negedge bus_clk);
        adv_n = 1'b1;
        check(wait_n == 1'b0, "R2", int'(wait_n), 0);
        repeat (LAT) @(negedge bus_clk);
        host_drv = 1'b1; host_val = d;
        wait_ready();
        cs_n = 1'b1; we_n = 1'b1; host_drv = 1'b0;
        check(wr_cnt == c0 + 1, "R3", wr_cnt - c0, 1);
        check(last_waddr == AW'(a), "R1", int'(last_waddr), a);
        check(last_wdata == d, "R3", int'(last_wdata), int'(d)); // R6: no contention
    endtask

    task automatic host_read(input int a, input logic [DW-1:0] exp);
        int c0;
        logic [DW-1:0] v;
        c0 = rd_cnt;
        @(negedge bus_clk);
        cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; addr = AW'(a);
        @(negedge bus_clk);
        adv_n = 1'b1;
        check(wait_n == 1'b0, "R2", int'(wait_n), 0);
        repeat (LAT) @(negedge bus_clk);
        oe_n = 1'b0;
        wait_ready();
        v = bus_data;
        cs_n = 1'b1; oe_n = 1'b1;
        check(v == exp, "R5", int'(v), int'(exp));
        check(rd_cnt == c0 + 1, "R4", rd_cnt - c0, 1);
        check(last_raddr == AW'(a), "R4", int'(last_raddr), a);
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c_w, c_r;
        for (int i = 0; i < NA; i++) mem[i] = '0;
        repeat (10) @(negedge bus_clk);
        // reset state, R2 and R7
        check(wait_n == 1'b1, "R2", int'(wait_n), 1);
        check(sys_wr == 1'b0 && sys_rd == 1'b0, "R7", int'({sys_wr, sys_rd}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge bus_clk);
        check(wait_n == 1'b1, "R2", int'(wait_n), 1);

        // sweep 1: write every address
        for (int a = 0; a < NA; a++) host_write(a, pat1(a));
        // sweep 2: read back in reverse order
        for (int a = NA - 1; a >= 0; a--) host_read(a, pat1(a));

        // R1: incomplete start patterns are ignored
        c_w = wr_cnt; c_r = rd_cnt;
        @(negedge bus_clk);
        cs_n = 1'b0; adv_n = 1'b1; we_n = 1'b0; addr = AW'(5);
        for (int k = 0; k < 6; k++) begin
            @(negedge bus_clk);
            check(wait_n == 1'b1, "R1", int'(wait_n), 1);
        end
        cs_n = 1'b1; adv_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge bus_clk);
            check(wait_n == 1'b1, "R1", int'(wait_n), 1);
        end
        adv_n = 1'b1; we_n = 1'b1;
        repeat (40) @(negedge bus_clk);
        check(wr_cnt == c_w && rd_cnt == c_r, "R1", wr_cnt + rd_cnt, c_w + c_r);
        host_read(5, pat1(5));

        // sweep 3: back-to-back interleaved write/read (R8)
        for (int a = 0; a < NA; a++) begin
            host_write(a, pat2(a));
            host_read(a, pat2(a));
            check(wait_n == 1'b1, "R8", int'(wait_n), 1);
        end

        repeat (20) @(negedge bus_clk);
        check(dbl == 0, "R7", dbl, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule